// File: doc/BRIEF.md
# Pipelined bus memory slave with wait states

This block is a single-master AHB-Lite slave in front of a small register memory of 32-bit words. The master drives a transfer's address and control in one cycle, the address phase, and the slave moves the data in a following cycle, the data phase. Address and data phases of neighbouring transfers overlap. The slave can stretch every real transfer by a fixed, parameter-set number of wait states, from zero to three. It does this by holding its ready output low. While ready is low the master must also hold the next transfer's address phase, so the slave takes new control only on cycles where ready is high.

Byte, halfword and word transfers are supported, and writes update only the selected byte lanes. A transfer that names a word beyond the memory depth, or a size wider than the bus, gets the two-cycle ERROR response instead of an access. Idle and busy cycles from the master are answered at once with OKAY and never touch memory.

Top module: `ahbs_mem_slave`

## Requirements
- R1: A transfer type of 00 (idle) or 01 (busy) causes no memory access, and the following cycle shows ready high with response 0 (OKAY).
- R2: A legal NONSEQ (10) or SEQ (11) transfer holds ready low for exactly WAIT_STATES data-phase cycles, then shows ready high with response 0.
- R3: Address and control are taken only on a cycle with ready high, so a transfer presented during another transfer's wait states is carried out exactly once, at its own address.
- R4: A write (direction bit 1) changes only the enabled lanes, using write data from the last data-phase cycle. Size 0 is a byte in lane haddr[1:0], size 1 is a halfword in lanes 1:0 (haddr[1]=0) or 3:2 (haddr[1]=1), and size 2 is the whole word. Lane n is bits 8n+7:8n.
- R5: A read (direction bit 0) returns the whole addressed word on hrdata in the data-phase cycle where ready is high.
- R6: A word index haddr[31:2] at or above DEPTH gives ERROR: ready low with response 1, then ready high with response 1. No memory is written.
- R7: A size value above 2 gives the same two-cycle ERROR response and no access.
- R8: After reset, ready is high, the response is OKAY and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock, rising edge |
| hresetn | input | 1 | Active-low reset |
| haddr | input | 32 | Byte address of the transfer |
| htrans | input | 2 | Transfer type: 00 idle, 01 busy, 10 nonseq, 11 seq |
| hwrite | input | 1 | 1 write, 0 read |
| hsize | input | 3 | 0 byte, 1 halfword, 2 word; larger is illegal |
| hwdata | input | 32 | Write data, valid in the data phase |
| hrdata | output | 32 | Read data, valid when ready is high in a read data phase |
| hready | output | 1 | High when the current data phase completes |
| hresp | output | 1 | 0 OKAY, 1 ERROR |

## Verification
The hardest situation to reach is a new transfer sitting in its address phase while the previous data phase is still in its wait states. The slave must keep the older transfer's control and take the newer one only once, on the ready-high edge. The stimulus therefore issues transfers back to back with no idle cycles between them. It also places an error transfer directly between two legal ones, so the second error cycle overlaps a live address phase. Every read then checks that each pipelined write landed exactly once and only in its own lanes.

// File: rtl/ahbs_pkg.sv
package ahbs_pkg;
   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } trans_e;

   localparam logic RESP_OKAY  = 1'b0;
   localparam logic RESP_ERROR = 1'b1;

   localparam logic [2:0] SZ_BYTE = 3'd0;
   localparam logic [2:0] SZ_HALF = 3'd1;
   localparam logic [2:0] SZ_WORD = 3'd2;

   localparam int LANES = 4;
endpackage

// File: rtl/ahbs_decode.sv
module ahbs_decode #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4
) (
   input  logic [31:0]      addr,
   input  logic [2:0]       size,
   output logic [IDX_W-1:0] idx,
   output logic [3:0]       lanes,
   output logic             err
);
   import ahbs_pkg::*;

   logic out_range;
   logic bad_size;

   assign out_range = ({2'b00, addr[31:2]} >= 32'(DEPTH));
   assign bad_size  = (size > SZ_WORD);
   assign err       = out_range | bad_size;
   assign idx       = addr[IDX_W+1:2];

   always_comb begin
      unique case (size)
         SZ_BYTE: lanes = 4'b0001 << addr[1:0];
         SZ_HALF: lanes = addr[1] ? 4'b1100 : 4'b0011;
         default: lanes = 4'b1111;
      endcase
   end
endmodule

// File: rtl/ahbs_dphase.sv
module ahbs_dphase #(
   parameter int WAIT_STATES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic take_err,
   output logic ready,
   output logic resp
);
   import ahbs_pkg::*;

   logic dp_valid;
   logic dp_err;
   logic err_2nd;
   logic ok_rdy;

   generate
      if (WAIT_STATES == 0) begin : g_nowait
         assign ok_rdy = 1'b1;
      end else begin : g_wait
         localparam int CW = 2;
         logic [CW-1:0] cnt;
         assign ok_rdy = (cnt == CW'(WAIT_STATES));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else if (ready) cnt <= '0;
            else if (!dp_err) cnt <= cnt + 1'b1;
         end
         a_r2_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CW'(WAIT_STATES));
      end
   endgenerate

   assign ready = !dp_valid ? 1'b1 : (dp_err ? err_2nd : ok_rdy);
   assign resp  = (dp_valid && dp_err) ? RESP_ERROR : RESP_OKAY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_valid <= 1'b0;
         dp_err   <= 1'b0;
         err_2nd  <= 1'b0;
      end else if (ready) begin
         dp_valid <= take;
         dp_err   <= take & take_err;
         err_2nd  <= 1'b0;
      end else if (dp_err) begin
         err_2nd  <= 1'b1;
      end
   end

   a_r6_err_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && resp) |=> (ready && resp));
   a_r6_err_preceded: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && resp) |-> $past(!ready && resp));
endmodule

// File: rtl/ahbs_regmem.sv
module ahbs_regmem #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [3:0]       lanes,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata
);
   logic [31:0] mem [DEPTH];

   generate
      for (genvar w = 0; w < DEPTH; w++) begin : g_word
         for (genvar b = 0; b < 4; b++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) mem[w][8*b +: 8] <= 8'h00;
               else if (we && lanes[b] && (idx == IDX_W'(w)))
                  mem[w][8*b +: 8] <= wdata[8*b +: 8];
            end
         end
      end
   endgenerate

   assign rdata = mem[idx];
endmodule

// File: rtl/ahbs_mem_slave.sv
module ahbs_mem_slave #(
   parameter int DEPTH       = 16,
   parameter int WAIT_STATES = 1
) (
   input  logic        hclk,
   input  logic        hresetn,
   input  logic [31:0] haddr,
   input  logic [1:0]  htrans,
   input  logic        hwrite,
   input  logic [2:0]  hsize,
   input  logic [31:0] hwdata,
   output logic [31:0] hrdata,
   output logic        hready,
   output logic        hresp
);
   import ahbs_pkg::*;

   localparam int IDX_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;

   generate
      if (WAIT_STATES < 0 || WAIT_STATES > 3) begin : g_bad_wait
         $error("WAIT_STATES must lie in 0..3");
      end
      if (DEPTH < 2 || DEPTH != (1 << IDX_W) || IDX_W > 30) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic             active;
   logic             take;
   logic [IDX_W-1:0] a_idx;
   logic [3:0]       a_lanes;
   logic             a_err;

   logic [IDX_W-1:0] dp_idx;
   logic [3:0]       dp_lanes;
   logic             dp_wr;
   logic             dp_rd;
   logic             we;
   logic [31:0]      mem_rdata;

   assign active = (htrans == TR_NONSEQ) || (htrans == TR_SEQ);
   assign take   = active && hready;

   ahbs_decode #(.DEPTH(DEPTH), .IDX_W(IDX_W)) dec_i (
      .addr  (haddr),
      .size  (hsize),
      .idx   (a_idx),
      .lanes (a_lanes),
      .err   (a_err)
   );

   ahbs_dphase #(.WAIT_STATES(WAIT_STATES)) dph_i (
      .clk      (hclk),
      .rst_n    (hresetn),
      .take     (take),
      .take_err (a_err),
      .ready    (hready),
      .resp     (hresp)
   );

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         dp_idx   <= '0;
         dp_lanes <= '0;
         dp_wr    <= 1'b0;
         dp_rd    <= 1'b0;
      end else if (hready) begin
         if (take) begin
            dp_idx   <= a_idx;
            dp_lanes <= a_lanes;
         end
         dp_wr <= take & hwrite & ~a_err;
         dp_rd <= take & ~hwrite & ~a_err;
      end
   end

   assign we = dp_wr & hready;

   ahbs_regmem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) mem_i (
      .clk   (hclk),
      .rst_n (hresetn),
      .we    (we),
      .idx   (dp_idx),
      .lanes (dp_lanes),
      .wdata (hwdata),
      .rdata (mem_rdata)
   );

   assign hrdata = dp_rd ? mem_rdata : '0;

   // R1: an idle or busy cycle accepted is answered next cycle with OKAY, no wait
   a_r1_idle_okay: assert property (@(posedge hclk) disable iff (!hresetn)
      (hready && !active) |=> (hready && !hresp));
   // R3: data-phase control is frozen during wait states
   a_r3_hold_ctl: assert property (@(posedge hclk) disable iff (!hresetn)
      !hready |=> ($stable(dp_idx) && $stable(dp_lanes)));
   // R6/R7: an error response never writes memory
   a_r6_no_write: assert property (@(posedge hclk) disable iff (!hresetn)
      hresp |-> !we);
   // R7: an illegal size leads to an error data phase
   a_r7_size_err: assert property (@(posedge hclk) disable iff (!hresetn)
      (take && hsize > SZ_WORD) |=> hresp);
endmodule

// File: tb/ahbs_mem_slave_tb_top.sv
module ahbs_mem_slave_tb_top;
   localparam int DEPTH = 16;
   localparam int WS    = 1;

   logic        hclk = 1'b0;
   logic        hresetn = 1'b0;
   logic [31:0] haddr = '0;
   logic [1:0]  htrans = 2'b00;
   logic        hwrite = 1'b0;
   logic [2:0]  hsize = 3'd2;
   logic [31:0] hwdata = '0;
   logic [31:0] hrdata;
   logic        hready;
   logic        hresp;

   always #4 hclk = ~hclk;

   ahbs_mem_slave #(.DEPTH(DEPTH), .WAIT_STATES(WS)) dut_i (
      .hclk(hclk), .hresetn(hresetn), .haddr(haddr), .htrans(htrans),
      .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
      .hrdata(hrdata), .hready(hready), .hresp(hresp)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   logic [31:0] model [DEPTH];
   bit          q_err [$];
   bit          q_rd  [$];
   logic [31:0] q_dat [$];
   string       q_tag [$];
   logic [31:0] pend_wdata = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] lanes_of(input logic [31:0] a, input logic [2:0] s);
      if (s == 3'd0) return 4'b0001 << a[1:0];
      if (s == 3'd1) return a[1] ? 4'b1100 : 4'b0011;
      return 4'b1111;
   endfunction

   // driver: one address phase, held until ready is high, expected item queued
   task automatic xfer(input logic [1:0] tr, input bit wr, input logic [31:0] a,
                       input logic [2:0] s, input logic [31:0] wd, input string tag);
      bit rdy;
      bit err;
      logic [3:0] ln;
      logic [31:0] w;
      @(negedge hclk);
      htrans = tr; hwrite = wr; haddr = a; hsize = s; hwdata = pend_wdata;
      if (tr[1]) begin
         err = (a[31:2] >= DEPTH) || (s > 3'd2);
         q_err.push_back(err);
         q_rd.push_back(!wr && !err);
         q_tag.push_back(tag);
         if (!wr && !err) q_dat.push_back(model[a[5:2]]);
         else q_dat.push_back('0);
         if (wr && !err) begin
            ln = lanes_of(a, s);
            w = model[a[5:2]];
            for (int b = 0; b < 4; b++) if (ln[b]) w[8*b +: 8] = wd[8*b +: 8];
            model[a[5:2]] = w;
         end
      end
      pend_wdata = wd;
      do begin
         #3 rdy = hready;
         if (!rdy) @(negedge hclk);
      end while (!rdy);
   endtask

   // monitor: pops the expected item when a data phase completes
   bit in_dp = 0;
   int wcnt = 0;
   initial begin
      forever begin
         @(negedge hclk);
         #2;
         if (!hresetn || finished) continue;
         if (!in_dp) begin
            chk(hready && !hresp, "R1 idle/busy answered at once", {30'd0, hready, hresp}, 32'h2);
         end else if (hready) begin
            if (q_err.size() == 0) begin
               chk(0, "R3 data phase with no transfer", 32'd1, 32'd0);
            end else begin
               bit e, r;
               logic [31:0] d;
               string t;
               e = q_err.pop_front(); r = q_rd.pop_front();
               d = q_dat.pop_front(); t = q_tag.pop_front();
               chk(hresp == e, {t, " response"}, {31'd0, hresp}, {31'd0, e});
               chk(wcnt == (e ? 1 : WS), e ? "R6 error low cycles" : "R2 wait states",
                   32'(wcnt), 32'(e ? 1 : WS));
               if (r) chk(hrdata == d, {t, " read data"}, hrdata, d);
            end
            wcnt = 0;
         end else begin
            wcnt++;
            if (q_err.size() != 0 && q_err[0])
               chk(hresp == 1'b1, "R6 first error cycle", {31'd0, hresp}, 32'd1);
         end
         if (hready) in_dp = htrans[1];
      end
   end

   initial begin
      int cyc = 0;
      while (!finished && cyc < 20000) begin
         @(posedge hclk);
         cyc++;
      end
      if (!finished) begin
         finished = 1;
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   localparam logic [1:0] NS = 2'b10, SQ = 2'b11, ID = 2'b00, BY = 2'b01;

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      repeat (3) @(negedge hclk);
      #2;
      chk(hready == 1'b1 && hresp == 1'b0, "R8 reset outputs", {30'd0, hready, hresp}, 32'h2);
      hresetn = 1'b1;
      // R8: memory zero after reset
      xfer(NS, 0, 32'h0000_001C, 3'd2, '0, "R8 reset contents");
      // back-to-back writes and reads across wait states (R3, R4, R5)
      xfer(NS, 1, 32'h0000_0000, 3'd2, 32'hA5A5_1234, "R4 word write");
      xfer(SQ, 1, 32'h0000_0004, 3'd2, 32'h1122_3344, "R3 pipelined write");
      xfer(NS, 1, 32'h0000_0008, 3'd2, 32'h5566_7788, "R4 word write");
      xfer(NS, 1, 32'h0000_0009, 3'd0, 32'hDEAD_BEEF, "R4 byte lane 1");
      xfer(NS, 1, 32'h0000_000E, 3'd1, 32'hCAFE_0000, "R4 upper half");
      xfer(NS, 1, 32'h0000_000C, 3'd1, 32'h0000_BABE, "R4 lower half");
      xfer(NS, 0, 32'h0000_0000, 3'd2, '0, "R5 read word 0");
      xfer(SQ, 0, 32'h0000_0004, 3'd2, '0, "R3 read after pipelined write");
      xfer(SQ, 0, 32'h0000_0008, 3'd2, '0, "R4 byte merge read");
      xfer(SQ, 0, 32'h0000_000C, 3'd2, '0, "R4 halfword merge read");
      // R1: busy and idle with write set do not touch memory
      xfer(BY, 1, 32'h0000_0000, 3'd2, 32'hFFFF_FFFF, "R1 busy");
      xfer(ID, 1, 32'h0000_0004, 3'd2, 32'hFFFF_FFFF, "R1 idle");
      xfer(ID, 0, 32'h0000_0000, 3'd2, 32'hFFFF_FFFF, "R1 idle");
      xfer(NS, 0, 32'h0000_0000, 3'd2, '0, "R1 word 0 untouched");
      xfer(SQ, 0, 32'h0000_0004, 3'd2, '0, "R1 word 1 untouched");
      // R6: out-of-range write, between legal transfers
      xfer(NS, 1, 32'h0000_0040, 3'd2, 32'h0BAD_0BAD, "R6 out of range");
      xfer(NS, 0, 32'h0000_0000, 3'd2, '0, "R6 no alias write");
      xfer(NS, 0, 32'h0000_1000, 3'd2, '0, "R6 far read");
      // R7: illegal size
      xfer(NS, 1, 32'h0000_0004, 3'd3, 32'h7777_7777, "R7 size 3");
      xfer(NS, 1, 32'h0000_0004, 3'd7, 32'h6666_6666, "R7 size 7");
      xfer(NS, 0, 32'h0000_0004, 3'd2, '0, "R7 word unchanged");
      // R4: write data taken from final data-phase cycle; full lanes byte 3
      xfer(NS, 1, 32'h0000_003F, 3'd0, 32'h9900_0000, "R4 byte lane 3");
      xfer(NS, 0, 32'h0000_003C, 3'd2, '0, "R4 last word read");
      xfer(ID, 0, 32'h0000_0000, 3'd2, '0, "flush");
      xfer(ID, 0, 32'h0000_0000, 3'd2, '0, "flush");
      repeat (3) @(negedge hclk);
      chk(q_err.size() == 0, "R3 all transfers completed", 32'(q_err.size()), 32'd0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule